// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Status Controller

This block keeps the control and status word of one bulk OUT endpoint in a full-speed USB device. A protocol engine reports each OUT token, the data bytes that follow it, and whether the packet ended well or badly. The block then picks the handshake for that transaction. STALL comes first, then NAK when there is no room, and otherwise ACK. Accepted packets go into one of two 64-byte receive buffers.

The CPU sees one status word. It drains the active buffer one byte at a time through a read strobe on the data port. It clears flags by writing ones to them and can request a stall. A token finite-state machine has four states: `S_IDLE`, `S_RECV`, `S_NAK` and `S_STALL`. It moves between them as follows:
- `S_IDLE` goes to `S_STALL` on a token while a stall is requested.
- `S_IDLE` goes to `S_NAK` on a token while both buffers are full.
- `S_IDLE` goes to `S_RECV` on any other token.
- Every other state returns to `S_IDLE` when the packet ends, whether it ended well or with an error.

A buffer is released when its last byte is read, or when the processed flag is cleared on a zero-length packet. On release, the active role moves to the other buffer.

Top module: `usbo_ep_ctrl`

## Requirements
- R1: After reset the status word reads 0 and `hs_vld` is low.
- R2: Status bits are: bit 7 short packet, bit 6 data pending, bit 5 stall request, bit 4 stall entered, bit 1 packet processed, bit 0 buffer occupied. Bits 31..8, 3 and 2 always read 0. Writing ones to them has no effect.
- R3: Writing 1 to bit 5 requests a stall. The next OUT token that arrives in `S_IDLE` is answered with STALL (`hs_code` 2). Its data is not stored. Bit 4 is set in the cycle after that token, and only by this event.
- R4: Bit 5 clears in the same cycle that bit 4 sets. The next OUT token is handled normally.
- R5: If the stall request is written during a transaction, that transaction still completes with ACK. Bit 4 stays 0 until a later token.
- R6: Writing 1 to bit 4 clears it.
- R7: A good packet that lands in a free buffer is answered with ACK (`hs_code` 0). `hs_vld` pulses in the cycle after the packet-end input. `hs_vld` is never asserted unless packet-end was high in the previous cycle.
- R8: When both buffers are full, a token is answered with NAK (`hs_code` 1). The stored data stays unchanged.
- R9: Bytes read from `dat_rdata` come out in arrival order, one per `dat_rd` pulse. Bit 6 is high while unread bytes remain and falls once the last byte has been read.
- R10: Bit 7 is 1 when the active packet holds fewer than 64 bytes. When the last byte is read and the other buffer holds a packet, bit 7 takes that packet's value. When neither buffer holds a packet, bit 7 keeps its value until the next packet lands in the active buffer.
- R11: A zero-length packet reads as bit 7 = 1 with bit 6 = 0. While it is active, a `dat_rd` pulse changes neither `dat_rdata` nor the status word. Clearing bit 1 releases it.
- R12: Bit 1 is set when a packet becomes active, either by landing in an empty active buffer or by a handoff. Writing 1 to bit 1 clears it unless a handoff happens in the same cycle.
- R13: Bit 0 is 1 while the active buffer holds a packet.
- R14: A packet that ends with `pkt_err` gets no handshake and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | OUT token seen by the protocol engine |
| pkt_vld | input | 1 | Data byte valid |
| pkt_byte | input | 8 | Received data byte |
| pkt_end | input | 1 | Packet ended with good CRC |
| pkt_err | input | 1 | Packet ended with an error |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 32 | Write data (set or write-one-to-clear per bit) |
| csr_rdata | output | 32 | Status word |
| dat_rd | input | 1 | Byte read strobe on the data port |
| dat_rdata | output | 8 | Byte at the head of the active buffer |
| hs_vld | output | 1 | Handshake valid |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |

## Verification
The assertions assume the engine follows the protocol:
- Every token is followed by exactly one `pkt_end` or `pkt_err`.
- Data bytes appear only between a token and its end.
- A new token never arrives before the previous transaction has closed.

The zero-length check also assumes no status write happens in the same cycle as the read strobe. The directed tasks drive every transaction as a strict sequence: token, then bytes, then end. Status writes are kept apart from read strobes, with one exception: a stall request placed on purpose during a data phase.

// File: rtl/usbo_ep_pkg.sv
package usbo_ep_pkg;
    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_NAK,
        S_STALL
    } ep_state_t;

    localparam int BIT_RSP = 7;
    localparam int BIT_RNE = 6;
    localparam int BIT_FST = 5;
    localparam int BIT_SST = 4;
    localparam int BIT_RPC = 1;
    localparam int BIT_RFS = 0;
endpackage

// File: rtl/usbo_ep_fsm.sv
module usbo_ep_fsm
    import usbo_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok,
    input  logic       pkt_end,
    input  logic       pkt_err,
    input  logic       both_full,
    input  logic       fst_set,
    input  logic       sst_clr,
    output logic       tok_acc,
    output logic       commit,
    output logic       wr_en,
    output logic       hs_vld,
    output logic [1:0] hs_code,
    output logic       fst,
    output logic       sst
);
    ep_state_t state, nxt;
    logic      enter;
    logic      hs_n_vld;
    hs_t       hs_n;

    // State register and the flags it drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            fst     <= 1'b0;
            sst     <= 1'b0;
            hs_vld  <= 1'b0;
            hs_code <= HS_ACK;
        end else begin
            state   <= nxt;
            fst     <= fst_set | (fst & ~enter);
            sst     <= enter | (sst & ~sst_clr);
            hs_vld  <= hs_n_vld;
            hs_code <= hs_n;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt      = state;
        enter    = 1'b0;
        tok_acc  = 1'b0;
        commit   = 1'b0;
        hs_n_vld = 1'b0;
        hs_n     = HS_ACK;
        wr_en    = (state == S_RECV);
        unique case (state)
            S_IDLE: begin
                if (tok) begin
                    if (fst) begin
                        nxt   = S_STALL;
                        enter = 1'b1;
                    end else if (both_full) begin
                        nxt = S_NAK;
                    end else begin
                        nxt     = S_RECV;
                        tok_acc = 1'b1;
                    end
                end
            end
            S_RECV: begin
                if (pkt_end) begin
                    nxt      = S_IDLE;
                    commit   = 1'b1;
                    hs_n_vld = 1'b1;
                    hs_n     = HS_ACK;
                end else if (pkt_err) begin
                    nxt = S_IDLE;
                end
            end
            S_NAK: begin
                if (pkt_end) begin
                    nxt      = S_IDLE;
                    hs_n_vld = 1'b1;
                    hs_n     = HS_NAK;
                end else if (pkt_err) begin
                    nxt = S_IDLE;
                end
            end
            S_STALL: begin
                if (pkt_end) begin
                    nxt      = S_IDLE;
                    hs_n_vld = 1'b1;
                    hs_n     = HS_STALL;
                end else if (pkt_err) begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/usbo_ep_bufs.sv
module usbo_ep_bufs #(
    parameter int MAXP = 64,
    localparam int AW = $clog2(MAXP),
    localparam int CW = $clog2(MAXP + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_acc,
    input  logic       wr_vld,
    input  logic [7:0] wr_byte,
    input  logic       commit,
    input  logic       rd_stb,
    input  logic       rpc_clr,
    output logic [7:0] rdata,
    output logic       rne,
    output logic       rsp,
    output logic       rpc,
    output logic       rfs,
    output logic       both_full
);
    logic [7:0]    mem [2][MAXP];
    logic [1:0]    full;
    logic [1:0]    shrt;
    logic [CW-1:0] cnt [2];
    logic          act, fill;
    logic [CW-1:0] wcnt, rptr;
    logic          rd_go, last_rd, zlp_rel, rel;
    logic          new_short, commit_act, commit_oth, oth_full, oth_short, set_rpc;

    assign rne        = full[act] && (rptr != cnt[act]);
    assign rfs        = full[act];
    assign both_full  = &full;
    assign rdata      = mem[act][rptr[AW-1:0]];
    assign rd_go      = rd_stb && rne;
    assign last_rd    = rd_go && ((rptr + 1'b1) == cnt[act]);
    assign zlp_rel    = rpc_clr && full[act] && !rne;
    assign rel        = last_rd || zlp_rel;
    assign new_short  = (wcnt < CW'(MAXP));
    assign commit_act = commit && (fill == act);
    assign commit_oth = commit && (fill != act);
    assign oth_full   = full[~act] || commit_oth;
    assign oth_short  = commit_oth ? new_short : shrt[~act];
    assign set_rpc    = commit_act || (rel && oth_full);

    always_ff @(posedge clk) begin
        if (wr_vld && (wcnt < CW'(MAXP)))
            mem[fill][wcnt[AW-1:0]] <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= '0;
            shrt   <= '0;
            cnt[0] <= '0;
            cnt[1] <= '0;
            act    <= 1'b0;
            fill   <= 1'b0;
            wcnt   <= '0;
            rptr   <= '0;
            rpc    <= 1'b0;
            rsp    <= 1'b0;
        end else begin
            if (tok_acc) begin
                fill <= full[act] ? ~act : act;
                wcnt <= '0;
            end else if (wr_vld && (wcnt < CW'(MAXP))) begin
                wcnt <= wcnt + 1'b1;
            end
            if (commit) begin
                full[fill] <= 1'b1;
                cnt[fill]  <= wcnt;
                shrt[fill] <= new_short;
            end
            if (rel) begin
                full[act] <= 1'b0;
                act       <= ~act;
                rptr      <= '0;
            end else if (rd_go) begin
                rptr <= rptr + 1'b1;
            end
            rpc <= set_rpc | (rpc & ~rpc_clr);
            if (commit_act)
                rsp <= new_short;
            else if (rel && oth_full)
                rsp <= oth_short;
        end
    end
endmodule

// File: rtl/usbo_ep_ctrl.sv
module usbo_ep_ctrl
    import usbo_ep_pkg::*;
#(
    parameter int MAXP = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tok_out,
    input  logic        pkt_vld,
    input  logic [7:0]  pkt_byte,
    input  logic        pkt_end,
    input  logic        pkt_err,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        dat_rd,
    output logic [7:0]  dat_rdata,
    output logic        hs_vld,
    output logic [1:0]  hs_code
);
    logic tok_acc, commit, wr_en, fst, sst, both_full;
    logic rne, rsp, rpc, rfs;

    usbo_ep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok       (tok_out),
        .pkt_end   (pkt_end),
        .pkt_err   (pkt_err),
        .both_full (both_full),
        .fst_set   (csr_wr && csr_wdata[BIT_FST]),
        .sst_clr   (csr_wr && csr_wdata[BIT_SST]),
        .tok_acc   (tok_acc),
        .commit    (commit),
        .wr_en     (wr_en),
        .hs_vld    (hs_vld),
        .hs_code   (hs_code),
        .fst       (fst),
        .sst       (sst)
    );

    usbo_ep_bufs #(.MAXP(MAXP)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_acc   (tok_acc),
        .wr_vld    (wr_en && pkt_vld),
        .wr_byte   (pkt_byte),
        .commit    (commit),
        .rd_stb    (dat_rd),
        .rpc_clr   (csr_wr && csr_wdata[BIT_RPC]),
        .rdata     (dat_rdata),
        .rne       (rne),
        .rsp       (rsp),
        .rpc       (rpc),
        .rfs       (rfs),
        .both_full (both_full)
    );

    always_comb begin
        csr_rdata          = '0;
        csr_rdata[BIT_RSP] = rsp;
        csr_rdata[BIT_RNE] = rne;
        csr_rdata[BIT_FST] = fst;
        csr_rdata[BIT_SST] = sst;
        csr_rdata[BIT_RPC] = rpc;
        csr_rdata[BIT_RFS] = rfs;
    end
endmodule

// File: rtl/usbo_ep_chk.sv
module usbo_ep_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tok_out,
    input logic        pkt_vld,
    input logic [7:0]  pkt_byte,
    input logic        pkt_end,
    input logic        pkt_err,
    input logic        csr_wr,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        dat_rd,
    input logic [7:0]  dat_rdata,
    input logic        hs_vld,
    input logic [1:0]  hs_code
);
    AST_SST_NEEDS_FST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[4]) |-> $past(csr_rdata[5])); // R3

    AST_FST_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csr_rdata[4]) && !$past(csr_wr && csr_wdata[5])) |-> !csr_rdata[5]); // R4

    AST_HS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        hs_vld |-> $past(pkt_end)); // R7

    AST_RNE_NEEDS_RFS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[6] |-> csr_rdata[0]); // R9

    AST_ZLP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[7] && !csr_rdata[6] && csr_rdata[0] && dat_rd && !csr_wr)
        |=> ($stable(dat_rdata) && $stable(csr_rdata[0]))); // R11

    AST_ERR_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pkt_err) && !$past(pkt_end)) |-> !hs_vld); // R14

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[31:8] == 24'd0) && (csr_rdata[3:2] == 2'd0)); // R2
endmodule

bind usbo_ep_ctrl usbo_ep_chk u_chk (.*);

// File: tb/tb_usbo_ep_ctrl.sv
`timescale 1ns/1ps
module tb_usbo_ep_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_out = 1'b0, pkt_vld = 1'b0, pkt_end = 1'b0, pkt_err = 1'b0;
    logic [7:0]  pkt_byte = 8'd0;
    logic        csr_wr = 1'b0, dat_rd = 1'b0;
    logic [31:0] csr_wdata = 32'd0;
    logic [31:0] csr_rdata;
    logic [7:0]  dat_rdata;
    logic        hs_vld;
    logic [1:0]  hs_code;
    int          n_chk = 0, n_bad = 0;
    logic        v;
    logic [1:0]  c;
    logic [31:0] snap;

    always #2.5 clk = ~clk;

    usbo_ep_ctrl dut (.*);

    function automatic logic [31:0] st(logic rsp, logic rne, logic fst, logic sst, logic rpc, logic rfs);
        return {24'd0, rsp, rne, fst, sst, 2'b00, rpc, rfs};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic csr_write(logic [31:0] val);
        csr_wr = 1'b1; csr_wdata = val;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = 32'd0;
    endtask

    task automatic send_pkt(int n, logic [7:0] base, output logic hv, output logic [1:0] hc, output logic [31:0] sn);
        tok_out = 1'b1;
        @(negedge clk);
        tok_out = 1'b0;
        sn = csr_rdata;
        for (int i = 0; i < n; i++) begin
            pkt_vld = 1'b1; pkt_byte = base + 8'(i);
            @(negedge clk);
        end
        pkt_vld = 1'b0; pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        hv = hs_vld; hc = hs_code;
    endtask

    task automatic read_bytes(int n, logic [7:0] base, string req);
        for (int i = 0; i < n; i++) begin
            check(req, {24'd0, dat_rdata}, {24'd0, base + 8'(i)});
            dat_rd = 1'b1;
            @(negedge clk);
            dat_rd = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1 status", csr_rdata, 32'd0);
        check("R1 hs", {31'd0, hs_vld}, 32'd0);
    endtask

    task automatic t_full_pkt;
        send_pkt(64, 8'h10, v, c, snap);
        check("R7 ack", {30'd0, v, c[0] | c[1]}, 32'd2);
        check("R13 R12 status", csr_rdata, st(0,1,0,0,1,1));
        read_bytes(64, 8'h10, "R9 data");
        check("R9 drained", csr_rdata, st(0,0,0,0,1,0));
        csr_write(32'h2);
        check("R12 clear", csr_rdata, 32'd0);
    endtask

    task automatic t_two_nak;
        send_pkt(5, 8'h40, v, c, snap);
        check("R10 short", csr_rdata, st(1,1,0,0,1,1));
        send_pkt(64, 8'h80, v, c, snap);
        check("R10 second", csr_rdata, st(1,1,0,0,1,1));
        send_pkt(7, 8'hC0, v, c, snap);
        check("R8 nak", {30'd0, v, c[1]}, 32'd2);
        check("R8 nak code", {30'd0, c}, 32'd1);
        csr_write(32'h2);
        check("R12 clr no handoff", csr_rdata, st(1,1,0,0,0,1));
        read_bytes(5, 8'h40, "R9 short data");
        check("R10 R12 handoff", csr_rdata, st(0,1,0,0,1,1));
        read_bytes(64, 8'h80, "R8 data kept");
        check("R9 empty", csr_rdata, st(0,0,0,0,1,0));
        csr_write(32'h2);
    endtask

    task automatic t_zlp;
        logic [7:0] d0;
        send_pkt(0, 8'h00, v, c, snap);
        check("R11 zlp status", csr_rdata, st(1,0,0,0,1,1));
        d0 = dat_rdata;
        dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
        check("R11 read ignored", csr_rdata, st(1,0,0,0,1,1));
        check("R11 data stable", {24'd0, dat_rdata}, {24'd0, d0});
        send_pkt(3, 8'h21, v, c, snap);
        check("R7 ack other", {30'd0, v, c}, 32'h4);
        csr_write(32'h2);
        check("R11 R12 release", csr_rdata, st(1,1,0,0,1,1));
        read_bytes(3, 8'h21, "R9 after zlp");
        check("R10 hold", csr_rdata, st(1,0,0,0,1,0));
        csr_write(32'h2);
        check("R12 cleared", csr_rdata, st(1,0,0,0,0,0));
    endtask

    task automatic t_stall;
        csr_write(32'h20);
        check("R3 fst set", csr_rdata, st(1,0,1,0,0,0));
        send_pkt(4, 8'h33, v, c, snap);
        check("R3 stall hs", {30'd0, v, c[1]}, 32'd3);
        check("R4 same cycle", snap & 32'h30, 32'h10);
        check("R3 nothing stored", csr_rdata, st(1,0,0,1,0,0));
        send_pkt(2, 8'h55, v, c, snap);
        check("R4 normal ack", {29'd0, v, c}, 32'h4);
        check("R4 status", csr_rdata, st(1,1,0,1,1,1));
        csr_write(32'h10);
        check("R6 sst clear", csr_rdata, st(1,1,0,0,1,1));
        read_bytes(2, 8'h55, "R9 post stall");
        csr_write(32'h2);
    endtask

    task automatic t_fst_mid;
        tok_out = 1'b1;
        @(negedge clk);
        tok_out = 1'b0;
        pkt_vld = 1'b1; pkt_byte = 8'h61; csr_wr = 1'b1; csr_wdata = 32'h20;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = 32'd0; pkt_byte = 8'h62;
        @(negedge clk);
        pkt_vld = 1'b0; pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        check("R5 ack", {29'd0, hs_vld, hs_code}, 32'h4);
        check("R5 status", csr_rdata, st(1,1,1,0,1,1));
        send_pkt(1, 8'h70, v, c, snap);
        check("R5 later stall", {29'd0, v, c}, 32'h6);
        check("R5 sst", csr_rdata, st(1,1,0,1,1,1));
        csr_write(32'h12);
        check("R6 R12 clear", csr_rdata, st(1,1,0,0,0,1));
        read_bytes(2, 8'h61, "R5 data");
        check("R9 empty", csr_rdata, st(1,0,0,0,0,0));
    endtask

    task automatic t_err;
        tok_out = 1'b1;
        @(negedge clk);
        tok_out = 1'b0; pkt_vld = 1'b1; pkt_byte = 8'hEE;
        @(negedge clk);
        pkt_vld = 1'b0; pkt_err = 1'b1;
        @(negedge clk);
        pkt_err = 1'b0;
        check("R14 no hs", {31'd0, hs_vld}, 32'd0);
        check("R14 nothing stored", csr_rdata, st(1,0,0,0,0,0));
        send_pkt(1, 8'h99, v, c, snap);
        check("R14 next ack", {29'd0, v, c}, 32'h4);
        read_bytes(1, 8'h99, "R14 data");
        csr_write(32'h2);
    endtask

    task automatic t_reserved;
        csr_write(32'hFFFF_FF0C);
        check("R2 reserved", csr_rdata, st(1,0,0,0,0,0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_full_pkt;
        t_two_nak;
        t_zlp;
        t_stall;
        t_fst_mid;
        t_err;
        t_reserved;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=hang exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule